// File: doc/BRIEF.md
# Keyboard Scan Code Event Parser

This block sits after a keyboard serial receiver. It takes the received bytes one at a time and turns the scan-code set 2 byte sequences into single key events. The extended prefix byte (0xE0) and the release marker byte (0xF0) never leave the block on their own. They change how the byte that completes the sequence is reported. Each event carries a 16-bit key code and a flag that tells a press from a release. The upper byte of the code is 0x00 for plain keys and 0xE0 for extended keys.

Both sides of the block are valid/ready streams. An event is registered and appears on the output in the cycle after its completing byte is accepted. It stays there, unchanged, until the consumer takes it with `out_ready`. While a held event is waiting, `in_ready` is low, so the producer must stall. When `out_ready` is high, `in_ready` is high as well, and one byte can be accepted every cycle. A synchronous reset drops any sequence that is only partly received.

Top module: `kbd_scan_evt`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `out_valid` is 0 and `in_ready` is 1. A prefix or marker received before reset has no effect on the bytes received after reset.
- R2: In the idle state, a byte other than 0xE0 or 0xF0 gives a press event (`out_release`=0) with code {0x00, byte}. `out_valid` rises in the cycle after the byte is accepted.
- R3: In the idle state, 0xE0 is stored as an extended prefix. If the next byte is anything except 0xF0, it gives a press event with code {0xE0, byte}.
- R4: In the idle state, 0xF0 starts a release. The next byte gives a release event (`out_release`=1) with code {0x00, byte}, whatever the value of that byte.
- R5: After 0xE0, a 0xF0 starts a release that keeps the prefix. The next byte gives a release event with code {0xE0, byte}.
- R6: Accepting 0xE0 in the idle state, or 0xF0 in the idle or extended state, gives no event in the following cycle.
- R7: After each event the parser is back in the idle state, so the next byte is decoded as the first byte of a new sequence.
- R8: While `out_valid`=1 and `out_ready`=0, `out_code` and `out_release` stay stable, `out_valid` stays 1, and `in_ready` is 0.
- R9: When `out_ready` is high, each event keeps `out_valid` high for exactly one cycle, unless another event completes in that same cycle.
- R10: A byte is taken only when `in_valid` and `in_ready` are both high. Without an accepted byte, no new event appears.
- R11: The arrow keys decode as the press codes 0xE075 (up), 0xE072 (down), 0xE06B (left) and 0xE074 (right).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Received byte is present |
| in_ready | output | 1 | Block can accept a byte |
| in_byte | input | 8 | Received scan code byte |
| out_valid | output | 1 | Key event is present |
| out_ready | input | 1 | Consumer takes the event |
| out_code | output | 16 | Key code: prefix byte in the upper half, key byte in the lower half |
| out_release | output | 1 | 1 = release, 0 = press |

## Verification
Directed sequences cover each of the four sequence shapes: a plain byte, prefix then byte, marker then byte, and prefix then marker then byte. Comparing these shows that the prefix and the marker each set their own part of the event and do not interfere with each other. Odd orders also get directed runs: a prefix followed by another prefix, a marker followed by 0xE0 or 0xF0, and a reset in the middle of a sequence. These show that only the state at the time a byte arrives decides what the byte means. Random byte streams weighted toward 0xE0 and 0xF0, with random gaps in `in_valid` and random stalls on `out_ready`, are checked against a reference model in the bench. They exercise back-to-back events, the return to the idle state after every event, and holding an event under back-pressure.

// File: rtl/kbd_evt_pkg.sv
package kbd_evt_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_EXT  = 2'd1,
    SEQ_REL  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/kbd_seq_fsm.sv
module kbd_seq_fsm #(
  parameter int               BYTE_W   = 8,
  parameter logic [BYTE_W-1:0] EXT_CODE = 8'hE0,
  parameter logic [BYTE_W-1:0] REL_CODE = 8'hF0,
  localparam int              CODE_W   = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              done,
  output logic [CODE_W-1:0] done_code,
  output logic              done_rel
);
  import kbd_evt_pkg::*;

  seq_state_e        state_q, state_d;
  logic [BYTE_W-1:0] hi_q, hi_d;
  logic              is_ext, is_rel;

  assign is_ext = (byte_i == EXT_CODE);
  assign is_rel = (byte_i == REL_CODE);

  always_comb begin
    state_d   = state_q;
    hi_d      = hi_q;
    done      = 1'b0;
    done_rel  = 1'b0;
    done_code = {hi_q, byte_i};
    if (take) begin
      unique case (state_q)
        SEQ_IDLE: begin
          if (is_ext) begin
            state_d = SEQ_EXT;
            hi_d    = byte_i;
          end else if (is_rel) begin
            state_d = SEQ_REL;
            hi_d    = '0;
          end else begin
            done      = 1'b1;
            done_code = {{BYTE_W{1'b0}}, byte_i};
          end
        end
        SEQ_EXT: begin
          if (is_rel) begin
            state_d = SEQ_REL;
          end else begin
            done    = 1'b1;
            state_d = SEQ_IDLE;
          end
        end
        SEQ_REL: begin
          done     = 1'b1;
          done_rel = 1'b1;
          state_d  = SEQ_IDLE;
        end
        default: state_d = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
      hi_q    <= '0;
    end else begin
      state_q <= state_d;
      hi_q    <= hi_d;
    end
  end
endmodule

// File: rtl/kbd_evt_hold.sv
module kbd_evt_hold #(
  parameter int CODE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [CODE_W-1:0] load_code,
  input  logic              load_rel,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [CODE_W-1:0] out_code,
  output logic              out_release,
  output logic              can_load
);
  assign can_load = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_code    <= '0;
      out_release <= 1'b0;
    end else if (load) begin
      out_valid   <= 1'b1;
      out_code    <= load_code;
      out_release <= load_rel;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end
endmodule

// File: rtl/kbd_scan_evt.sv
module kbd_scan_evt #(
  parameter int               BYTE_W   = 8,
  parameter logic [BYTE_W-1:0] EXT_CODE = 8'hE0,
  parameter logic [BYTE_W-1:0] REL_CODE = 8'hF0,
  localparam int              CODE_W   = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CODE_W-1:0] out_code,
  output logic              out_release
);
  logic              take, done, done_rel;
  logic [CODE_W-1:0] done_code;

  assign take = in_valid && in_ready;

  kbd_seq_fsm #(
    .BYTE_W(BYTE_W), .EXT_CODE(EXT_CODE), .REL_CODE(REL_CODE)
  ) seq_i (
    .clk(clk), .rst(rst), .take(take), .byte_i(in_byte),
    .done(done), .done_code(done_code), .done_rel(done_rel)
  );

  kbd_evt_hold #(.CODE_W(CODE_W)) hold_i (
    .clk(clk), .rst(rst), .load(done), .load_code(done_code),
    .load_rel(done_rel), .out_ready(out_ready), .out_valid(out_valid),
    .out_code(out_code), .out_release(out_release), .can_load(in_ready)
  );
endmodule

// File: rtl/kbd_scan_evt_chk.sv
module kbd_scan_evt_chk #(
  parameter int CODE_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [CODE_W-1:0] out_code,
  input logic              out_release
);
  p_reset_idle_r1: assert property (@(posedge clk) rst |=> !out_valid);

  p_hold_stable_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_code) && $stable(out_release)));

  p_stall_input_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  p_no_spurious_r10: assert property (@(posedge clk) disable iff (rst)
    (!(in_valid && in_ready) && !(out_valid && !out_ready)) |=> !out_valid);
endmodule

bind kbd_scan_evt kbd_scan_evt_chk #(.CODE_W(CODE_W)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_code(out_code),
  .out_release(out_release)
);

// File: tb/kbd_scan_evt_tb_top.sv
module kbd_scan_evt_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  in_byte = 8'h00;
  logic        out_ready = 1'b1;
  logic        in_ready, out_valid, out_release;
  logic [15:0] out_code;

  int n_tests = 0;
  int n_fail  = 0;

  // reference model
  int          m_st = 0;   // 0 idle, 1 prefix seen, 2 release marker seen
  logic [7:0]  m_hi = 8'h00;
  logic        m_v = 1'b0;
  logic [15:0] m_code = 16'h0;
  logic        m_rel = 1'b0;

  always #4 clk = ~clk;

  kbd_scan_evt dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_byte(in_byte), .out_valid(out_valid), .out_ready(out_ready),
    .out_code(out_code), .out_release(out_release)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_step(input logic v, input logic [7:0] b, input logic rdy);
    logic acc;
    logic done;
    acc  = v && (!m_v || rdy);
    done = 1'b0;
    if (acc) begin
      case (m_st)
        0: if (b == 8'hE0) begin m_st = 1; m_hi = b; end
           else if (b == 8'hF0) begin m_st = 2; m_hi = 8'h00; end
           else begin done = 1'b1; m_code = {8'h00, b}; m_rel = 1'b0; end
        1: if (b == 8'hF0) m_st = 2;
           else begin done = 1'b1; m_code = {m_hi, b}; m_rel = 1'b0; m_st = 0; end
        default: begin done = 1'b1; m_code = {m_hi, b}; m_rel = 1'b1; m_st = 0; end
      endcase
    end
    if (done) m_v = 1'b1;
    else if (rdy) m_v = 1'b0;
  endtask

  // called at a negedge; returns at the next negedge with outputs checked
  task automatic step(input logic v, input logic [7:0] b, input logic rdy, input string tag);
    in_valid  = v;
    in_byte   = b;
    out_ready = rdy;
    #1;
    chk({tag, " in_ready"}, {15'h0, in_ready}, {15'h0, (!m_v || rdy)});
    @(posedge clk);
    model_step(v, b, rdy);
    @(negedge clk);
    chk({tag, " out_valid"}, {15'h0, out_valid}, {15'h0, m_v});
    if (m_v) begin
      chk({tag, " out_code"}, out_code, m_code);
      chk({tag, " out_release"}, {15'h0, out_release}, {15'h0, m_rel});
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    in_valid = 1'b0;
    @(negedge clk);
    chk("R1 in reset out_valid", {15'h0, out_valid}, 16'h0);
    @(negedge clk);
    rst = 1'b0;
    m_st = 0; m_hi = 8'h00; m_v = 1'b0;
    #1;
    chk("R1 after reset out_valid", {15'h0, out_valid}, 16'h0);
    chk("R1 after reset in_ready", {15'h0, in_ready}, 16'h1);
  endtask

  task automatic seq_expect(input string tag, input logic [7:0] b0, input logic [7:0] b1,
                            input logic [7:0] b2, input int n,
                            input logic [15:0] code, input logic rel);
    if (n > 2) step(1'b1, b0, 1'b1, tag);
    if (n > 1) step(1'b1, (n > 2) ? b1 : b0, 1'b1, tag);
    step(1'b1, (n > 2) ? b2 : ((n > 1) ? b1 : b0), 1'b1, tag);
    chk({tag, " direct valid"}, {15'h0, out_valid}, 16'h1);
    chk({tag, " direct code"}, out_code, code);
    chk({tag, " direct rel"}, {15'h0, out_release}, {15'h0, rel});
    step(1'b0, 8'h00, 1'b1, {tag, " idle"});
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();

    seq_expect("R2 plain", 8'h1C, 8'h00, 8'h00, 1, 16'h001C, 1'b0);
    seq_expect("R3 ext press", 8'hE0, 8'h4A, 8'h00, 2, 16'hE04A, 1'b0);
    seq_expect("R4 release", 8'hF0, 8'h1C, 8'h00, 2, 16'h001C, 1'b1);
    seq_expect("R5 ext release", 8'hE0, 8'hF0, 8'h6B, 3, 16'hE06B, 1'b1);
    seq_expect("R11 up", 8'hE0, 8'h75, 8'h00, 2, 16'hE075, 1'b0);
    seq_expect("R11 down", 8'hE0, 8'h72, 8'h00, 2, 16'hE072, 1'b0);
    seq_expect("R11 left", 8'hE0, 8'h6B, 8'h00, 2, 16'hE06B, 1'b0);
    seq_expect("R11 right", 8'hE0, 8'h74, 8'h00, 2, 16'hE074, 1'b0);
    seq_expect("R3 double prefix", 8'hE0, 8'hE0, 8'h00, 2, 16'hE0E0, 1'b0);
    seq_expect("R4 release of F0", 8'hF0, 8'hF0, 8'h00, 2, 16'h00F0, 1'b1);
    seq_expect("R4 release of E0", 8'hF0, 8'hE0, 8'h00, 2, 16'h00E0, 1'b1);

    // R6: prefix and marker give no event
    step(1'b1, 8'hE0, 1'b1, "R6 prefix quiet");
    chk("R6 prefix no event", {15'h0, out_valid}, 16'h0);
    step(1'b1, 8'hF0, 1'b1, "R6 marker quiet");
    chk("R6 marker no event", {15'h0, out_valid}, 16'h0);
    step(1'b1, 8'h12, 1'b1, "R5 finish");
    // R7: back to idle, next byte is plain press
    step(1'b1, 8'h12, 1'b1, "R7 fresh");
    chk("R7 fresh press", out_code, 16'h0012);
    chk("R9 one-cycle strobe", {15'h0, out_valid}, 16'h1);
    step(1'b0, 8'h00, 1'b1, "R9 drop");
    chk("R9 strobe dropped", {15'h0, out_valid}, 16'h0);

    // R10: bytes without valid ignored
    step(1'b0, 8'hE0, 1'b1, "R10 no valid");
    step(1'b0, 8'hF0, 1'b1, "R10 no valid");
    step(1'b1, 8'h33, 1'b1, "R10 plain after ignored");
    chk("R10 ignored bytes no effect", out_code, 16'h0033);

    // R8: back-pressure
    step(1'b0, 8'h00, 1'b1, "R8 gap");
    step(1'b1, 8'h44, 1'b0, "R8 load");
    step(1'b1, 8'h55, 1'b0, "R8 stall");
    chk("R8 held code", out_code, 16'h0044);
    step(1'b1, 8'h55, 1'b0, "R8 stall2");
    step(1'b1, 8'h55, 1'b1, "R8 release");
    chk("R8 next code", out_code, 16'h0055);
    step(1'b0, 8'h00, 1'b1, "R8 drain");

    // R1: reset discards partial sequence
    step(1'b1, 8'hE0, 1'b1, "R1 partial");
    step(1'b1, 8'hF0, 1'b1, "R1 partial");
    do_reset();
    step(1'b1, 8'h75, 1'b1, "R1 post reset");
    chk("R1 partial discarded code", out_code, 16'h0075);
    chk("R1 partial discarded rel", {15'h0, out_release}, 16'h0);

    // random phase
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] b;
      int sel;
      sel = $urandom_range(0, 9);
      b = (sel < 2) ? 8'hE0 : (sel < 4) ? 8'hF0 : 8'($urandom_range(0, 255));
      step(($urandom_range(0, 3) != 0), b, ($urandom_range(0, 4) != 0), "R7 random");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule